// File: doc/BRIEF.md
# ECC Word Access and Byte Lane Controller

This block connects a narrow request bus, either 8 or 16 bits wide, to an internal storage array. Each array word holds 64 data bits and 7 Hamming check bits. A read fetches the whole word, corrects any single-bit error on the way out, and places the addressed byte or halfword on the response bus. The correction is applied only to the returned value. The stored cells stay as they are.

A write is a read-modify-write. The block fetches the word, corrects it, and merges in the new byte or halfword. It then computes fresh check bits and issues one masked array write. The mask selects only the cells whose stored value differs from the new codeword. A word that already holds the requested value causes no array write. A latent single-bit error in the target word is repaired by any write to that word.

Control is a four-state machine:
- IDLE: waits for `req_valid`. On `start` it goes to FETCH.
- FETCH: reads the array. It always moves on to CHECK.
- CHECK: decodes and corrects the word. On `answer` (a read) it returns to IDLE. On `unchanged` (a write whose mask is zero) it also returns to IDLE. On `differs` (a write with a nonzero mask) it goes to COMMIT.
- COMMIT: issues the masked write. On `retire` it returns to IDLE.

Top module: `ecc_lane_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `arr_en` and `rsp_valid` are 0.
- R2: The stored codeword has data in bits [63:0] and check bits in [70:64]. Codeword positions 1 to 71 are used as follows: powers of two are reserved for check bits, and data bits 0 to 63 fill the other positions in ascending order. Check bit k is the parity of the data bits whose position has bit k set.
- R3: The word address is request address bits [19:2]. In 16-bit mode, lane `addr[1:0]` returns data bits [16*lane+15:16*lane], and `addr[20]` is ignored. In 8-bit mode, byte `{addr[20],addr[1:0]}` returns bits [8*b+7:8*b] on `rsp_rdata[7:0]`, and bits [15:8] of the response are 0.
- R4: A request accepted at a clock edge drives an array read (`arr_en`=1, `arr_we`=0) at `arr_addr` in the following cycle.
- R5: For a read, `rsp_valid` is high for one cycle, in the cycle after the array read. Data with a single flipped data bit or check bit is returned corrected. `rsp_corrected` pulses with `rsp_valid`. No array write follows.
- R6: A write whose new codeword differs from the stored one issues exactly one array write, in the cycle after the check cycle. `arr_wdata` is the full new codeword and `arr_wmask` is the stored codeword XOR the new one. A write produces no `rsp_valid`.
- R7: A write that leaves the word unchanged issues no array write.
- R8: A write to a word that holds a single-bit error leaves the whole corrected and merged codeword in the array. The error bit is included in the mask.
- R9: `req_ready` is 0 from the cycle after acceptance until the request retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_x8 | input | 1 | 1 = 8-bit lane mode, 0 = 16-bit |
| req_addr | input | 21 | Request address |
| req_wdata | input | 16 | Write data (bits [7:0] only in 8-bit mode) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Corrected read lane |
| rsp_corrected | output | 1 | A correction was applied to this read |
| arr_en | output | 1 | Array access |
| arr_we | output | 1 | Array write (with arr_en) |
| arr_addr | output | 18 | Array word address |
| arr_wdata | output | 71 | New codeword |
| arr_wmask | output | 71 | Per-bit write mask |
| arr_rdata | input | 71 | Array read codeword, one cycle after read |

## Verification
A state machine stuck outside IDLE shows as `req_ready` staying low. A skipped FETCH shows as the wrong `arr_addr` or a missing read in the cycle after acceptance. A bad syndrome-to-bit mapping returns the wrong lane value, or sets `rsp_corrected` on clean words, in the first read of an affected word. A stale or wrong mask register shows at the single COMMIT cycle as an `arr_wmask` that is not the stored XOR new codeword. It also shows later as an array word that no longer matches the expected encoding.

// File: rtl/ecc_lane_pkg.sv
`timescale 1ns/1ps
package ecc_lane_pkg;
    localparam int DATA_W  = 64;
    localparam int PAR_W   = 7;
    localparam int CODE_W  = DATA_W + PAR_W;
    localparam int BUS_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 21;
    localparam int WORD_AW = 18;
    localparam int HSEL_W  = $clog2(DATA_W / BUS_W);
    localparam int SEL_W   = $clog2(DATA_W / BYTE_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_COMMIT
    } ctl_state_t;

    // Codeword position (1-based) of data bit i; powers of two hold check bits.
    function automatic int unsigned data_pos(int unsigned i);
        int unsigned p;
        int unsigned n;
        p = 0;
        n = 0;
        for (int unsigned q = 1; q <= CODE_W; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == i) p = q;
                n++;
            end
        end
        return p;
    endfunction

    // Data bits covered by check bit k.
    function automatic logic [DATA_W-1:0] cover_mask(int unsigned k);
        logic [DATA_W-1:0] m;
        int unsigned p;
        m = '0;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            p = data_pos(i);
            m[i] = p[k];
        end
        return m;
    endfunction
endpackage

// File: rtl/ecclc_hamming_enc.sv
`timescale 1ns/1ps
module ecclc_hamming_enc
    import ecc_lane_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W-1:0]  par
);
    for (genvar k = 0; k < PAR_W; k++) begin : g_par
        localparam logic [DATA_W-1:0] COVER = cover_mask(k);
        assign par[k] = ^(data & COVER);
    end
endmodule

// File: rtl/ecclc_hamming_fix.sv
`timescale 1ns/1ps
module ecclc_hamming_fix
    import ecc_lane_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data_fix,
    output logic              syn_nz
);
    logic [PAR_W-1:0]  par_re;
    logic [PAR_W-1:0]  syn;
    logic [DATA_W-1:0] flip;

    ecclc_hamming_enc u_reenc (
        .data (code[DATA_W-1:0]),
        .par  (par_re)
    );

    assign syn = par_re ^ code[CODE_W-1:DATA_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam int unsigned POS = data_pos(i);
        assign flip[i] = (syn == PAR_W'(POS));
    end

    assign data_fix = code[DATA_W-1:0] ^ flip;
    assign syn_nz   = (syn != '0);
endmodule

// File: rtl/ecclc_lane_steer.sv
`timescale 1ns/1ps
module ecclc_lane_steer
    import ecc_lane_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [SEL_W-1:0]  lane_sel,
    input  logic              x8,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rd_lane,
    output logic [DATA_W-1:0] merged
);
    always_comb begin
        merged  = word;
        rd_lane = '0;
        if (x8) begin
            rd_lane[BYTE_W-1:0] = word[int'(lane_sel) * BYTE_W +: BYTE_W];
            merged[int'(lane_sel) * BYTE_W +: BYTE_W] = wdata[BYTE_W-1:0];
        end else begin
            rd_lane = word[int'(lane_sel[HSEL_W-1:0]) * BUS_W +: BUS_W];
            merged[int'(lane_sel[HSEL_W-1:0]) * BUS_W +: BUS_W] = wdata;
        end
    end
endmodule

// File: rtl/ecc_lane_ctrl.sv
`timescale 1ns/1ps
module ecc_lane_ctrl
    import ecc_lane_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_x8,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BUS_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic [BUS_W-1:0]   rsp_rdata,
    output logic               rsp_corrected,
    output logic               arr_en,
    output logic               arr_we,
    output logic [WORD_AW-1:0] arr_addr,
    output logic [CODE_W-1:0]  arr_wdata,
    output logic [CODE_W-1:0]  arr_wmask,
    input  logic [CODE_W-1:0]  arr_rdata
);
    ctl_state_t state, state_nx;

    logic              q_write;
    logic              q_x8;
    logic [ADDR_W-1:0] q_addr;
    logic [BUS_W-1:0]  q_wdata;
    logic [CODE_W-1:0] commit_word;
    logic [CODE_W-1:0] commit_mask;

    logic [DATA_W-1:0] word_fix;
    logic              syn_nz;
    logic [SEL_W-1:0]  lane_sel;
    logic [BUS_W-1:0]  lane_rd;
    logic [DATA_W-1:0] merged;
    logic [PAR_W-1:0]  new_par;
    logic [CODE_W-1:0] new_code;
    logic [CODE_W-1:0] mask_nx;

    // Decode and correct the fetched word
    ecclc_hamming_fix u_fix (
        .code     (arr_rdata),
        .data_fix (word_fix),
        .syn_nz   (syn_nz)
    );

    // Lane select: high bit only in 8-bit mode
    assign lane_sel = q_x8 ? {q_addr[ADDR_W-1], q_addr[HSEL_W-1:0]}
                           : {1'b0, q_addr[HSEL_W-1:0]};

    ecclc_lane_steer u_lane (
        .word     (word_fix),
        .lane_sel (lane_sel),
        .x8       (q_x8),
        .wdata    (q_wdata),
        .rd_lane  (lane_rd),
        .merged   (merged)
    );

    ecclc_hamming_enc u_enc (
        .data (merged),
        .par  (new_par)
    );

    assign new_code = {new_par, merged};
    assign mask_nx  = arr_rdata ^ new_code;
    assign arr_addr = q_addr[WORD_AW+HSEL_W-1:HSEL_W];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_CHECK;
            ST_CHECK:  state_nx = (q_write && (mask_nx != '0)) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = ST_IDLE;
        endcase
    end

    // Request and commit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write     <= 1'b0;
            q_x8        <= 1'b0;
            q_addr      <= '0;
            q_wdata     <= '0;
            commit_word <= '0;
            commit_mask <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                q_write <= req_write;
                q_x8    <= req_x8;
                q_addr  <= req_addr;
                q_wdata <= req_wdata;
            end
            if (state == ST_CHECK) begin
                commit_word <= new_code;
                commit_mask <= mask_nx;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready     = 1'b0;
        arr_en        = 1'b0;
        arr_we        = 1'b0;
        arr_wdata     = commit_word;
        arr_wmask     = '0;
        rsp_valid     = 1'b0;
        rsp_rdata     = '0;
        rsp_corrected = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: arr_en = 1'b1;
            ST_CHECK: begin
                if (!q_write) begin
                    rsp_valid     = 1'b1;
                    rsp_rdata     = lane_rd;
                    rsp_corrected = syn_nz;
                end
            end
            ST_COMMIT: begin
                arr_en    = 1'b1;
                arr_we    = 1'b1;
                arr_wmask = commit_mask;
            end
        endcase
    end

    // Assertions
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    assert_fetch_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> arr_en && !arr_we);
    assert_mask_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> arr_en && (arr_wmask != '0));
    assert_flag_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_corrected |-> rsp_valid);
    assert_flag_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_corrected |=> !rsp_corrected);
    assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !arr_we);
    assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we && req_ready);
endmodule

// File: tb/ecc_lane_ctrl_tb.sv
`timescale 1ns/1ps
module ecc_lane_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_x8 = 1'b0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_corrected, arr_en, arr_we;
    logic [15:0] rsp_rdata;
    logic [17:0] arr_addr;
    logic [70:0] arr_wdata, arr_wmask, rdq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ecc_lane_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_x8(req_x8), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_corrected(rsp_corrected),
        .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_wmask(arr_wmask), .arr_rdata(rdq)
    );

    // Array model: 64 words, one-cycle read, per-bit masked write
    logic [70:0] mem [64];
    logic        ld_en = 1'b0;
    logic [5:0]  ld_idx = '0;
    logic [70:0] ld_val = '0;
    int          wr_count;

    always @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_val;
        else if (arr_en && arr_we)
            mem[arr_addr[5:0]] <= (mem[arr_addr[5:0]] & ~arr_wmask) | (arr_wdata & arr_wmask);
        else if (arr_en) rdq <= mem[arr_addr[5:0]];
    end
    always @(posedge clk) begin
        if (!rst_n) wr_count <= 0;
        else if (arr_en && arr_we) wr_count <= wr_count + 1;
    end

    logic [63:0] shadow [64];

    function automatic logic [70:0] tb_encode(input logic [63:0] d);
        logic [6:0] s;
        int di;
        s = '0;
        di = 0;
        for (int pos = 1; pos <= 71; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[di]) s = s ^ 7'(pos);
                di++;
            end
        end
        return {s, d};
    endfunction

    function automatic logic [15:0] tb_lane(input logic [63:0] w, input logic x8, input logic [20:0] a);
        if (x8) return {8'h00, w[8 * int'({a[20], a[1:0]}) +: 8]};
        return w[16 * int'(a[1:0]) +: 16];
    endfunction

    function automatic logic [63:0] tb_merge(input logic [63:0] w, input logic x8,
                                             input logic [20:0] a, input logic [15:0] d);
        logic [63:0] r;
        r = w;
        if (x8) r[8 * int'({a[20], a[1:0]}) +: 8] = d[7:0];
        else    r[16 * int'(a[1:0]) +: 16] = d;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [70:0] act, input logic [70:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_word(input int idx, input logic [70:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 6'(idx); ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_op(input logic wr, input logic x8, input logic [20:0] a, input logic [15:0] wd,
                          output logic fetch_ok, output logic got_rsp, output logic [15:0] rd,
                          output logic corr, output logic saw_wr, output logic [70:0] wm,
                          output logic [70:0] wdat);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_x8 = x8; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        fetch_ok = arr_en && !arr_we && !req_ready && (arr_addr == a[19:2]);
        @(negedge clk);
        got_rsp = rsp_valid; rd = rsp_rdata; corr = rsp_corrected;
        saw_wr = 1'b0; wm = '0; wdat = '0;
        n = 0;
        @(negedge clk);
        while (!req_ready && n < 20) begin
            if (arr_en && arr_we) begin saw_wr = 1'b1; wm = arr_wmask; wdat = arr_wdata; end
            n++;
            @(negedge clk);
        end
    endtask

    // Stimulus table: {write, x8, addr[20:0], wdata[15:0]}
    localparam int NOPS = 13;
    localparam logic [38:0] OPS [NOPS] = '{
        {1'b0, 1'b0, 21'h000000, 16'h0000},
        {1'b0, 1'b0, 21'h000007, 16'h0000},
        {1'b0, 1'b1, 21'h100009, 16'h0000},
        {1'b0, 1'b1, 21'h00000A, 16'h0000},
        {1'b1, 1'b0, 21'h00000D, 16'hA5C3},
        {1'b0, 1'b0, 21'h00000D, 16'h0000},
        {1'b1, 1'b1, 21'h10000E, 16'h005E},
        {1'b0, 1'b1, 21'h10000E, 16'h0000},
        {1'b0, 1'b0, 21'h00000F, 16'h0000},
        {1'b1, 1'b1, 21'h000010, 16'hFF11},
        {1'b0, 1'b0, 21'h000010, 16'h0000},
        {1'b0, 1'b1, 21'h100013, 16'h0000},
        {1'b0, 1'b0, 21'h100004, 16'h0000}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic fok, grsp, corr, swr;
        logic [15:0] rd;
        logic [70:0] wm, wdat, old;
        int wc;
        logic [63:0] nw;

        // Preload during reset
        for (int i = 0; i < 64; i++) begin
            shadow[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0303_0707_0F0F);
            load_word(i, tb_encode(shadow[i]));
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 71'(req_ready), 71'd1);
        chk(arr_en == 1'b0, "R1 arr_en in reset", 71'(arr_en), 71'd0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 71'(rsp_valid), 71'd0);
        rst_n = 1'b1;

        // Table walk
        for (int t = 0; t < NOPS; t++) begin
            logic wr, x8;
            logic [20:0] a;
            logic [15:0] wd;
            int w;
            {wr, x8, a, wd} = OPS[t];
            w = int'(a[7:2]);
            wc = wr_count;
            old = mem[w];
            run_op(wr, x8, a, wd, fok, grsp, rd, corr, swr, wm, wdat);
            chk(fok, "R4 R9 fetch cycle", 71'(fok), 71'd1);
            if (!wr) begin
                chk(grsp && rd == tb_lane(shadow[w], x8, a), "R3 lane read",
                    71'(rd), 71'(tb_lane(shadow[w], x8, a)));
                chk(!corr && wr_count == wc, "R5 clean read no flag no write", 71'(corr), 71'd0);
            end else begin
                shadow[w] = tb_merge(shadow[w], x8, a, wd);
                chk(swr && !grsp && wm == (old ^ tb_encode(shadow[w])), "R6 write mask",
                    wm, old ^ tb_encode(shadow[w]));
                chk(mem[w] == tb_encode(shadow[w]), "R2 stored codeword", mem[w], tb_encode(shadow[w]));
            end
        end

        // R5: data bit error corrected on output, array untouched
        old = tb_encode(shadow[5]) ^ (71'd1 << 37);
        load_word(5, old);
        wc = wr_count;
        run_op(1'b0, 1'b0, 21'h000016, 16'h0, fok, grsp, rd, corr, swr, wm, wdat);
        chk(grsp && rd == shadow[5][47:32], "R5 corrected data bit", 71'(rd), 71'(shadow[5][47:32]));
        chk(corr == 1'b1, "R5 correction flag", 71'(corr), 71'd1);
        chk(mem[5] == old && wr_count == wc, "R5 array not repaired by read", mem[5], old);

        // R5: check bit error
        load_word(6, tb_encode(shadow[6]) ^ (71'd1 << 66));
        run_op(1'b0, 1'b0, 21'h000018, 16'h0, fok, grsp, rd, corr, swr, wm, wdat);
        chk(grsp && rd == shadow[6][15:0] && corr, "R5 check bit error", 71'(rd), 71'(shadow[6][15:0]));

        // R7: unchanged write
        wc = wr_count;
        run_op(1'b1, 1'b0, 21'h000006, shadow[1][47:32], fok, grsp, rd, corr, swr, wm, wdat);
        chk(!swr && wr_count == wc, "R7 no write for same data", 71'(wr_count - wc), 71'd0);

        // R8: write repairs latent error
        old = tb_encode(shadow[7]) ^ (71'd1 << 3);
        load_word(7, old);
        nw = tb_merge(shadow[7], 1'b0, 21'h00001F, 16'h1234);
        shadow[7] = nw;
        run_op(1'b1, 1'b0, 21'h00001F, 16'h1234, fok, grsp, rd, corr, swr, wm, wdat);
        chk(swr && wm == (old ^ tb_encode(nw)) && wm[3], "R8 mask covers error bit", wm, old ^ tb_encode(nw));
        chk(wdat == tb_encode(nw), "R6 full codeword driven", wdat, tb_encode(nw));
        chk(mem[7] == tb_encode(nw), "R8 word repaired", mem[7], tb_encode(nw));
        chk(req_ready == 1'b1, "R9 ready after retire", 71'(req_ready), 71'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule